// File: doc/BRIEF.md
# Serial audio link frame receiver (codec side)

This block is the receive half of a codec's serial link to its digital audio controller. The controller sends one fixed-length frame for each audio sample period. The frame holds a 16-bit tag slot followed by twelve 20-bit slots. The block watches the frame strobe for a rising edge and shifts the serial data in, most significant bit first. From the tag it works out which slots carry meaning in the current frame. It then turns those slots into a register access request and into two playback samples for the DAC.

`clk_i` is the sampling edge of the link bit clock, so every input is taken on a rising edge of `clk_i`. The sample taken in the same cycle that the strobe is first seen high belongs to no frame. Bit 0 of the frame is taken on the next edge. Bits are then counted from there: the tag is frame bits 0–15, and slot n (n = 1..12) is frame bits 16+20(n−1) to 35+20(n−1). Each result comes out as a one-cycle strobe together with its fields. A data output keeps its value until its next strobe.

Top module: `aclink_rx_deframer`

## Requirements
- R1: A frame starts only when `sync_i` is sampled high after being sampled low. Holding `sync_i` high changes nothing. A new rising edge in the middle of a frame abandons the old frame, and no slot of the old frame that is still incomplete produces output.
- R2: Tag bit 15 (the first tag bit on the wire) is the frame-valid flag. Tag bits 14, 13, 12 and 11 mark slots 1, 2, 3 and 4 as valid.
- R3: When the frame-valid flag is 0, the frame produces no strobe of any kind, whatever the other tag bits hold.
- R4: A read is issued when slot 1 is tagged valid and slot 1 bit 19 is 1. `req_valid_o` is then high for the cycle after the edge that samples frame bit 35. In that cycle `req_rd_o`=1, `req_idx_o`=slot 1 bits 18:12, and `req_wdata_o`=0.
- R5: A write is issued when slots 1 and 2 are both tagged valid and slot 1 bit 19 is 0. `req_valid_o` is then high for the cycle after the edge that samples frame bit 55. In that cycle `req_rd_o`=0, `req_idx_o`=slot 1 bits 18:12, and `req_wdata_o`=slot 2 bits 19:4.
- R6: A write whose slot 2 is not tagged valid produces no request.
- R7: When slot 3 is tagged valid, `pcm_l_valid_o` is high for the cycle after the edge that samples frame bit 75, and `pcm_l_o`=slot 3 bits 19:2.
- R8: When slot 4 is tagged valid, `pcm_r_valid_o` is high for the cycle after the edge that samples frame bit 95, and `pcm_r_o`=slot 4 bits 19:2.
- R9: The following have no effect on any output: slots 5–12, reserved bits (slot 1 bits 11:0, slot 2 bits 3:0, PCM bits 1:0), and data sampled after frame bit 255 until the next rising edge of `sync_i`.
- R10: Every strobe is exactly one cycle wide.
- R11: While `rst_ni` is low, all strobes and data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link bit clock, sampling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame strobe; its rising edge starts a frame |
| sdata_i | input | 1 | Serial frame data, MSB first |
| req_valid_o | output | 1 | Register request strobe |
| req_rd_o | output | 1 | 1 = read, 0 = write |
| req_idx_o | output | 7 | Register index |
| req_wdata_o | output | 16 | Write data (0 for reads) |
| pcm_l_valid_o | output | 1 | Left sample strobe |
| pcm_l_o | output | 18 | Left DAC sample |
| pcm_r_valid_o | output | 1 | Right sample strobe |
| pcm_r_o | output | 18 | Right DAC sample |

## Verification
Each strobe is due exactly one cycle after the edge that samples the last bit of its slot. For a read that bit is frame bit 35, for a write 55, for the left sample 75 and for the right sample 95, where bit 0 is the sample that follows the edge on which the strobe rise is seen. The bench model replays the same driven bits into a per-frame bit array. In the step that drives one of those bits, the model computes what the design should show after the next edge, and it compares at the following falling edge, so every strobe is checked in its exact cycle. Per-scenario strobe counts then confirm the cases where nothing may come out: an invalid frame, a write without data, an abandoned frame, and trailing bits.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;
  localparam int TAG_BITS  = 16;
  localparam int SLOT_BITS = 20;
  localparam int NUM_SLOTS = 12;
  localparam int IDX_W     = 7;
  localparam int DATA_W    = 16;
  localparam int PCM_W     = 18;
  // slot numbers that carry decoded content
  localparam int SLOT_ADDR = 1;
  localparam int SLOT_DATA = 2;
  localparam int SLOT_PCM0 = 3;
  localparam int NUM_CH    = 2;
endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int TAG_BITS  = aclink_rx_pkg::TAG_BITS,
  parameter int SLOT_BITS = aclink_rx_pkg::SLOT_BITS,
  parameter int NUM_SLOTS = aclink_rx_pkg::NUM_SLOTS,
  localparam int SLOT_W   = $clog2(NUM_SLOTS + 1),
  localparam int MAX_LEN  = (TAG_BITS > SLOT_BITS) ? TAG_BITS : SLOT_BITS,
  localparam int BIT_W    = $clog2(MAX_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  output logic              sample_o,
  output logic              last_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic              sync_q, sync_rise, active_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q, end_bit;

  assign sync_rise = sync_i & ~sync_q;
  assign end_bit   = (slot_q == '0) ? BIT_W'(TAG_BITS - 1) : BIT_W'(SLOT_BITS - 1);
  // the sample taken with the strobe edge belongs to no frame
  assign sample_o  = active_q & ~sync_rise;
  assign last_o    = sample_o & (bit_q == end_bit);
  assign slot_o    = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else begin
      sync_q <= sync_i;
      if (sync_rise) begin
        active_q <= 1'b1;
        slot_q   <= '0;
        bit_q    <= '0;
      end else if (sample_o) begin
        if (last_o) begin
          bit_q <= '0;
          if (slot_q == SLOT_W'(NUM_SLOTS)) begin
            active_q <= 1'b0;
            slot_q   <= '0;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  a_r9_slot_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SLOT_W'(NUM_SLOTS));
  a_r9_stop_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && slot_q == SLOT_W'(NUM_SLOTS)) |=> !sample_o);
  a_r1_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !sync_q) |-> !last_o);
endmodule

// File: rtl/aclink_slot_shifter.sv
module aclink_slot_shifter #(
  parameter int W = aclink_rx_pkg::SLOT_BITS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-2:0] sh_q;

  // word includes the bit being sampled this cycle
  assign word_o = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= word_o[W-2:0];
  end
endmodule

// File: rtl/aclink_slot_dispatch.sv
module aclink_slot_dispatch #(
  parameter int TAG_BITS  = aclink_rx_pkg::TAG_BITS,
  parameter int SLOT_BITS = aclink_rx_pkg::SLOT_BITS,
  parameter int NUM_SLOTS = aclink_rx_pkg::NUM_SLOTS,
  parameter int IDX_W     = aclink_rx_pkg::IDX_W,
  parameter int DATA_W    = aclink_rx_pkg::DATA_W,
  parameter int PCM_W     = aclink_rx_pkg::PCM_W,
  parameter int NUM_CH    = aclink_rx_pkg::NUM_CH,
  localparam int SLOT_W   = $clog2(NUM_SLOTS + 1),
  localparam int FV_BIT   = TAG_BITS - 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         last_i,
  input  logic [SLOT_W-1:0]            slot_i,
  input  logic [SLOT_BITS-1:0]         word_i,
  output logic                         req_valid_o,
  output logic                         req_rd_o,
  output logic [IDX_W-1:0]             req_idx_o,
  output logic [DATA_W-1:0]            req_wdata_o,
  output logic [NUM_CH-1:0]            pcm_valid_o,
  output logic [NUM_CH-1:0][PCM_W-1:0] pcm_o
);
  import aclink_rx_pkg::*;

  logic [TAG_BITS-1:0] tag_q;
  logic                pend_wr_q;
  logic [IDX_W-1:0]    idx_hold_q;
  logic                frame_ok, ev_tag, ev_addr, ev_data, rw_bit;
  logic                unused_bits;

  assign frame_ok    = tag_q[FV_BIT];
  assign ev_tag      = last_i && (slot_i == '0);
  assign ev_addr     = last_i && (slot_i == SLOT_W'(SLOT_ADDR));
  assign ev_data     = last_i && (slot_i == SLOT_W'(SLOT_DATA));
  assign rw_bit      = word_i[SLOT_BITS-1];
  assign unused_bits = ^word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q       <= '0;
      pend_wr_q   <= 1'b0;
      idx_hold_q  <= '0;
      req_valid_o <= 1'b0;
      req_rd_o    <= 1'b0;
      req_idx_o   <= '0;
      req_wdata_o <= '0;
    end else begin
      req_valid_o <= 1'b0;
      if (ev_tag) begin
        tag_q     <= word_i[TAG_BITS-1:0];
        pend_wr_q <= 1'b0;
      end
      if (ev_addr && frame_ok && tag_q[FV_BIT-SLOT_ADDR]) begin
        if (rw_bit) begin
          req_valid_o <= 1'b1;
          req_rd_o    <= 1'b1;
          req_idx_o   <= word_i[SLOT_BITS-2 -: IDX_W];
          req_wdata_o <= '0;
        end else if (tag_q[FV_BIT-SLOT_DATA]) begin
          pend_wr_q  <= 1'b1;
          idx_hold_q <= word_i[SLOT_BITS-2 -: IDX_W];
        end
      end
      if (ev_data && pend_wr_q) begin
        pend_wr_q   <= 1'b0;
        req_valid_o <= 1'b1;
        req_rd_o    <= 1'b0;
        req_idx_o   <= idx_hold_q;
        req_wdata_o <= word_i[SLOT_BITS-1 -: DATA_W];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int SL = SLOT_PCM0 + ch;
    logic ev_pcm;
    assign ev_pcm = last_i && (slot_i == SLOT_W'(SL));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pcm_valid_o[ch] <= 1'b0;
        pcm_o[ch]       <= '0;
      end else begin
        pcm_valid_o[ch] <= 1'b0;
        if (ev_pcm && frame_ok && tag_q[FV_BIT-SL]) begin
          pcm_valid_o[ch] <= 1'b1;
          pcm_o[ch]       <= word_i[SLOT_BITS-1 -: PCM_W];
        end
      end
    end

    a_r10_pcm_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pcm_valid_o[ch] |=> !pcm_valid_o[ch]);
    a_r3_pcm_tagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pcm_valid_o[ch] |-> (tag_q[FV_BIT] && tag_q[FV_BIT-SL]));
  end

  a_r10_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);
  a_r5_write_tagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_rd_o) |->
      (tag_q[FV_BIT] && tag_q[FV_BIT-SLOT_ADDR] && tag_q[FV_BIT-SLOT_DATA]));
  a_r4_read_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_rd_o) |-> (req_wdata_o == '0));
  a_r6_pend_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_wr_q |-> tag_q[FV_BIT-SLOT_DATA]);
endmodule

// File: rtl/aclink_rx_deframer.sv
module aclink_rx_deframer #(
  parameter int TAG_BITS  = aclink_rx_pkg::TAG_BITS,
  parameter int SLOT_BITS = aclink_rx_pkg::SLOT_BITS,
  parameter int NUM_SLOTS = aclink_rx_pkg::NUM_SLOTS,
  parameter int IDX_W     = aclink_rx_pkg::IDX_W,
  parameter int DATA_W    = aclink_rx_pkg::DATA_W,
  parameter int PCM_W     = aclink_rx_pkg::PCM_W,
  localparam int SLOT_W   = $clog2(NUM_SLOTS + 1),
  localparam int NUM_CH   = aclink_rx_pkg::NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              sdata_i,
  output logic              req_valid_o,
  output logic              req_rd_o,
  output logic [IDX_W-1:0]  req_idx_o,
  output logic [DATA_W-1:0] req_wdata_o,
  output logic              pcm_l_valid_o,
  output logic [PCM_W-1:0]  pcm_l_o,
  output logic              pcm_r_valid_o,
  output logic [PCM_W-1:0]  pcm_r_o
);
  logic                         sample, last;
  logic [SLOT_W-1:0]            slot;
  logic [SLOT_BITS-1:0]         word;
  logic [NUM_CH-1:0]            pcm_valid;
  logic [NUM_CH-1:0][PCM_W-1:0] pcm;

  aclink_frame_timer #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .sample_o(sample), .last_o(last), .slot_o(slot)
  );

  aclink_slot_shifter #(.W(SLOT_BITS)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(sample), .bit_i(sdata_i), .word_o(word)
  );

  aclink_slot_dispatch #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS),
    .IDX_W(IDX_W), .DATA_W(DATA_W), .PCM_W(PCM_W), .NUM_CH(NUM_CH)
  ) u_disp (
    .clk_i(clk_i), .rst_ni(rst_ni), .last_i(last), .slot_i(slot), .word_i(word),
    .req_valid_o(req_valid_o), .req_rd_o(req_rd_o), .req_idx_o(req_idx_o),
    .req_wdata_o(req_wdata_o), .pcm_valid_o(pcm_valid), .pcm_o(pcm)
  );

  assign pcm_l_valid_o = pcm_valid[0];
  assign pcm_r_valid_o = pcm_valid[1];
  assign pcm_l_o       = pcm[0];
  assign pcm_r_o       = pcm[1];
endmodule

// File: tb/aclink_rx_deframer_tb_top.sv
module aclink_rx_deframer_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_i = 1'b0;
  logic sdata_i = 1'b0;
  logic req_valid_o, req_rd_o, pcm_l_valid_o, pcm_r_valid_o;
  logic [6:0]  req_idx_o;
  logic [15:0] req_wdata_o;
  logic [17:0] pcm_l_o, pcm_r_o;

  always #10 clk = ~clk;

  aclink_rx_deframer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .sdata_i(sdata_i),
    .req_valid_o(req_valid_o), .req_rd_o(req_rd_o), .req_idx_o(req_idx_o),
    .req_wdata_o(req_wdata_o), .pcm_l_valid_o(pcm_l_valid_o), .pcm_l_o(pcm_l_o),
    .pcm_r_valid_o(pcm_r_valid_o), .pcm_r_o(pcm_r_o)
  );

  int unsigned checks = 0, fails = 0;
  int unsigned n_req = 0, n_l = 0, n_r = 0;
  bit done = 1'b0;

  // reference model state
  bit   fb [0:255];
  int   pos = -1;
  bit   m_prev_sync = 1'b0;
  logic e_req = 0, e_rd = 0, e_l = 0, e_r = 0;
  logic [6:0]  e_idx = 0;
  logic [15:0] e_wd = 0;
  logic [17:0] e_pl = 0, e_pr = 0;

  function automatic logic [19:0] fld(int slot, int hi, int lo);
    logic [19:0] v = '0;
    for (int b = hi; b >= lo; b--) v = {v[18:0], fb[16 + 20*(slot-1) + 19 - b]};
    return v;
  endfunction

  function automatic bit tagb(int b);
    return fb[15 - b];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input bit s, input bit d);
    e_req = 0; e_l = 0; e_r = 0;
    if (s && !m_prev_sync) pos = 0;
    else if (pos >= 0) begin
      fb[pos] = d;
      if (pos == 35 && tagb(15) && tagb(14) && fb[16]) begin        // R4
        e_req = 1; e_rd = 1; e_idx = fld(1, 18, 12); e_wd = 0;
      end
      if (pos == 55 && tagb(15) && tagb(14) && tagb(13) && !fb[16]) begin // R5
        e_req = 1; e_rd = 0; e_idx = fld(1, 18, 12); e_wd = fld(2, 19, 4);
      end
      if (pos == 75 && tagb(15) && tagb(12)) begin e_l = 1; e_pl = fld(3, 19, 2); end
      if (pos == 95 && tagb(15) && tagb(11)) begin e_r = 1; e_pr = fld(4, 19, 2); end
      pos++;
      if (pos == 256) pos = -1;
    end
    m_prev_sync = s;
  endtask

  task automatic step(input bit s, input bit d);
    @(negedge clk);
    chk({req_valid_o, pcm_l_valid_o, pcm_r_valid_o} == {e_req, e_l, e_r},
        "R10 strobe timing", {req_valid_o, pcm_l_valid_o, pcm_r_valid_o}, {e_req, e_l, e_r});
    if (req_valid_o) n_req++;
    if (pcm_l_valid_o) n_l++;
    if (pcm_r_valid_o) n_r++;
    if (e_req) begin
      chk(req_rd_o == e_rd, "R4 access type", req_rd_o, e_rd);
      chk(req_idx_o == e_idx, "R4/R5 index", req_idx_o, e_idx);
      chk(req_wdata_o == e_wd, "R5 write data", req_wdata_o, e_wd);
    end
    if (e_l) chk(pcm_l_o == e_pl, "R7 left sample", pcm_l_o, e_pl);
    if (e_r) chk(pcm_r_o == e_pr, "R8 right sample", pcm_r_o, e_pr);
    sync_i = s; sdata_i = d;
    model(s, d);
  endtask

  task automatic run_frame(input logic [15:0] tag, input logic [19:0] s1, input logic [19:0] s2,
                           input logic [19:0] s3, input logic [19:0] s4,
                           input int nbits, input int sync_len, input int tail);
    logic [19:0] sl [1:12];
    sl[1] = s1; sl[2] = s2; sl[3] = s3; sl[4] = s4;
    for (int n = 5; n <= 12; n++) sl[n] = 20'($urandom);   // R9 junk in reserved slots
    step(1'b1, 1'($urandom));
    for (int k = 0; k < nbits; k++) begin
      bit b;
      if (k < 16) b = tag[15-k];
      else b = sl[(k-16)/20 + 1][19 - (k-16)%20];
      step(k + 1 < sync_len, b);
    end
    for (int t = 0; t < tail; t++) step(1'b0, 1'($urandom));
  endtask

  task automatic expect_counts(input string req, input int r, input int l, input int rr);
    chk(n_req == r && n_l == l && n_r == rr, req, {n_req[7:0], n_l[7:0], n_r[7:0]},
        {r[7:0], l[7:0], rr[7:0]});
    n_req = 0; n_l = 0; n_r = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({req_valid_o, pcm_l_valid_o, pcm_r_valid_o, req_rd_o} == 0 && req_idx_o == 0 &&
        req_wdata_o == 0 && pcm_l_o == 0 && pcm_r_o == 0, "R11 reset outputs",
        {req_wdata_o, req_idx_o}, 0);
    rst_ni = 1'b1;
    step(0, 0); step(0, 0);
    // R5 R7 R8: full write frame
    run_frame(16'hF800, {1'b0, 7'h02, 12'h0}, {16'h1234, 4'h0}, 20'hABCDC, 20'h5A5A4, 256, 16, 4);
    expect_counts("R5 R7 R8 full frame counts", 1, 1, 1);
    // R4: read, slot 3 data present but untagged
    run_frame(16'hC000, {1'b1, 7'h26, 12'h0}, 20'h0, 20'hFFFFF, 20'h0, 256, 16, 4);
    expect_counts("R4 read frame counts", 1, 0, 0);
    // R3: frame-valid clear
    run_frame(16'h7800, {1'b0, 7'h11, 12'h0}, 20'h77770, 20'h12340, 20'h43210, 256, 16, 4);
    expect_counts("R3 invalid frame counts", 0, 0, 0);
    // R6: write without slot 2 tag; R2 left slot alone
    run_frame(16'hD000, {1'b0, 7'h0C, 12'h0}, 20'h99990, 20'h80000, 20'h7FFFC, 256, 16, 4);
    expect_counts("R6 write without data counts", 0, 1, 0);
    // R9: reserved bits set, trailing junk after frame
    run_frame(16'hF87F, {1'b0, 7'h7F, 12'hFFF}, {16'hBEEF, 4'hF}, 20'h00003, 20'hFFFFF, 256, 16, 40);
    expect_counts("R9 reserved bits counts", 1, 1, 1);
    // R1: abort after slot 1, then restart with right slot only
    run_frame(16'hF800, {1'b0, 7'h05, 12'h0}, {16'hDEAD, 4'h0}, 20'h11110, 20'h22220, 40, 16, 0);
    run_frame(16'h8800, 20'h0, 20'h0, 20'h0, 20'h3C3C0, 256, 16, 4);
    expect_counts("R1 abort and restart counts", 0, 0, 1);
    // R1: strobe held high long
    run_frame(16'hF800, {1'b0, 7'h40, 12'h0}, {16'h0F0F, 4'h0}, 20'h55554, 20'hAAAA8, 256, 40, 0);
    // back-to-back frame with no gap
    run_frame(16'hB000, 20'h0, {16'h1111, 4'h0}, 20'h24680, 20'h0, 256, 16, 4);
    expect_counts("R1 long strobe and back-to-back counts", 1, 2, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule